// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This block is a 32-bit processor core that finishes each instruction within one clock period. In that period it fetches a word from a private instruction store, decodes it, reads two source registers, runs the arithmetic unit, optionally touches a private data store, and commits a result to the register bank or to memory. Eight operations are recognised: five register-to-register operations (add, subtract, and, or, signed set-less-than), a word load, a word store and a branch-if-equal. Every other encoding is a no-operation.

Program and data live in two separate word-wide arrays inside the core. The instruction array is read-only to the core and is filled from outside before reset is released. The data array is byte-addressed, but only whole words are moved. For observation, the core exposes on its ports each cycle what it commits: the register write, the memory store and the program counter of the instruction now executing.

Top module: `sc_cpu`

## Requirements
- R1: A low `rst_n` sampled at a rising edge sets the program counter to 0. While `rst_n` is low, no register or memory write is committed. After reset, an instruction that is not a taken branch moves the counter to its own address plus 4 at the next edge.
- R2: Branch-if-equal (opcode bits [31:26] = 6'h04) compares the registers named by bits [25:21] and [20:16]. If equal, the next counter is counter + 4 + (sign-extended bits [15:0] shifted left by 2); otherwise counter + 4. It writes no register and no memory.
- R3: Register operations use opcode 0 and a function code in bits [5:0]: 6'h20 add, 6'h22 subtract (first source minus second), 6'h24 and, 6'h25 or, 6'h2A signed less-than giving 1 or 0. Sources are in bits [25:21] and [20:16], and the result goes to the register in bits [15:11].
- R4: Load (opcode 6'h23) writes into the register in bits [20:16] the data word at address reg[bits 25:21] + sign-extended bits [15:0].
- R5: Store (opcode 6'h2B) writes the register named by bits [20:16] to the data word at reg[bits 25:21] + sign-extended bits [15:0]. It writes no register.
- R6: Register 0 always reads as zero, and a write aimed at it is dropped (`wb_en_o` stays 0).
- R7: Data and instruction word selection uses address bits [31:2] only. The two low bits do not change which word is read or written.
- R8: An opcode outside the four above, or opcode 0 with an unlisted function code, writes nothing and advances the counter by 4.
- R9: In the cycle an instruction executes, the trace ports show its committed register write (enable, index, value) and its committed store (enable, byte address, value). The committed writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| instr_o | output | 32 | Instruction word executing this cycle |
| wb_en_o | output | 1 | A register write commits at the next edge |
| wb_reg_o | output | 5 | Index of the register being written |
| wb_data_o | output | 32 | Value being written to the register |
| st_en_o | output | 1 | A data-store write commits at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Value being stored |

## Verification
The bench builds the core with 32-word instruction and data stores (`IMEM_WORDS=32`, `DMEM_WORDS=32`). With these sizes a short program holds a forward branch that skips two words, an untaken branch, an illegal opcode and a backward branch that wraps to address 0, and all of them fit in the array. The small data store lets a negative store offset and a load with nonzero low address bits land on words that an earlier store wrote, so the effects of the address arithmetic and of dropping the low bits show up on the trace ports. A reset raised in the middle of the run then checks that the write from the interrupted load is suppressed.

// File: rtl/cpu_pkg.sv
// Shared encodings and decode bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layout used throughout the core.
package cpu_pkg;

    localparam int XLEN = 32;

    // Major opcodes (instruction bits [31:26])
    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    // Function codes for register operations (instruction bits [5:0])
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // Arithmetic unit selections
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // Decoded control bundle
    typedef struct packed {
        logic    dst_is_rd;   // destination from bits [15:11] rather than [20:16]
        logic    reg_we;      // register bank write
        logic    b_is_imm;    // second operand is the extended immediate
        alu_op_e alu_op;      // arithmetic selection
        logic    mem_we;      // data store write
        logic    mem_re;      // data store read
        logic    wb_from_mem; // register value from data store
        logic    is_branch;   // branch-if-equal
    } ctrl_t;

endpackage

// File: rtl/cpu_ctrl.sv
// Instruction decoder: maps opcode and function code to the control bundle.
// Assumes unrecognised encodings must behave as a no-operation.
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Decode one instruction into datapath selects and write enables.
    always_comb begin
        ctrl = '{dst_is_rd: 1'b0, reg_we: 1'b0, b_is_imm: 1'b0, alu_op: ALU_ADD,
                 mem_we: 1'b0, mem_re: 1'b0, wb_from_mem: 1'b0, is_branch: 1'b0};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.mem_re      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_op    = ALU_SUB;
                ctrl.is_branch = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_alu.sv
// Arithmetic unit with five operations and an all-zero flag.
// Assumes set-less-than compares as two's complement numbers.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Compute the selected operation.
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    // Flag a result of zero for branch comparison.
    always_comb zero = (y == '0);

endmodule

// File: rtl/cpu_regfile.sv
// Register bank: two combinational read ports, one write port on the rising edge.
// Assumes entry 0 is hardwired to zero; its writes are dropped.
module cpu_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    // Clear the bank on reset, otherwise commit one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read both ports, forcing entry 0 to zero.
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    end

endmodule

// File: rtl/cpu_wordmem.sv
// Word-wide store addressed by byte address; bits [1:0] and bits above the
// depth are ignored. WRITABLE selects a read/write array or a read-only array
// whose contents are placed from outside before use.
module cpu_wordmem #(
    parameter int W        = 32,
    parameter int WORDS    = 64,
    parameter bit WRITABLE = 1'b1,
    localparam int AW      = $clog2(WORDS)
) (
    input  logic         clk,
    input  logic [W-1:0] addr,
    output logic [W-1:0] rdata,
    input  logic         we,
    input  logic [W-1:0] wdata
);

    logic [AW-1:0] widx;
    logic          unused_addr;

    // Select a word from the byte address.
    always_comb widx = addr[AW+1:2];
    assign unused_addr = ^{addr[W-1:AW+2], addr[1:0]};

    if (WRITABLE) begin : g_rw
        logic [W-1:0] mem [WORDS];

        // Commit one word write per edge.
        always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata;
        end

        // Combinational word read.
        always_comb rdata = mem[widx];
    end else begin : g_ro
        logic [W-1:0] rom [WORDS];
        logic         unused_wr;

        // Start empty; contents are filled from outside.
        initial begin
            for (int i = 0; i < WORDS; i++) rom[i] = '0;
        end

        assign unused_wr = ^{we, wdata, clk};

        // Combinational word read.
        always_comb rdata = rom[widx];
    end

endmodule

// File: rtl/sc_cpu.sv
// Single-cycle core: fetch, decode, execute, data access and write-back all
// complete between two rising edges. Assumes the instruction store is filled
// before rst_n is released; only the program counter and register bank reset.
module sc_cpu
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32,
    localparam int RAW       = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            wb_en_o,
    output logic [RAW-1:0]  wb_reg_o,
    output logic [XLEN-1:0] wb_data_o,
    output logic            st_en_o,
    output logic [XLEN-1:0] st_addr_o,
    output logic [XLEN-1:0] st_data_o
);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0] instr;
    logic [5:0]      opcode, funct;
    logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, dst_idx;
    logic [15:0]     imm16;
    logic [XLEN-1:0] imm_ext;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_val;
    logic            alu_zero, take_branch, rf_we, dm_we;
    logic            unused_fields;

    // Program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    cpu_wordmem #(.W(XLEN), .WORDS(IMEM_WORDS), .WRITABLE(1'b0)) u_imem (
        .clk   (clk),
        .addr  (pc_q),
        .rdata (instr),
        .we    (1'b0),
        .wdata ('0)
    );

    // Split the instruction word into its fields.
    always_comb begin
        opcode  = instr[31:26];
        rs_idx  = instr[25:21];
        rt_idx  = instr[20:16];
        rd_idx  = instr[15:11];
        funct   = instr[5:0];
        imm16   = instr[15:0];
        imm_ext = {{(XLEN-16){imm16[15]}}, imm16};
    end
    assign unused_fields = ^{instr[10:6], ctrl.mem_re};

    cpu_ctrl u_ctrl (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    cpu_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (rs_idx),
        .ra_b  (rt_idx),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (rf_we),
        .wa    (dst_idx),
        .wd    (wb_val)
    );

    // Pick the second operand for the arithmetic unit.
    always_comb alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    cpu_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    cpu_wordmem #(.W(XLEN), .WORDS(DMEM_WORDS), .WRITABLE(1'b1)) u_dmem (
        .clk   (clk),
        .addr  (alu_y),
        .rdata (mem_rdata),
        .we    (dm_we),
        .wdata (rt_val)
    );

    // Gate writes with reset and choose the write-back source and target.
    always_comb begin
        dm_we   = ctrl.mem_we & rst_n;
        rf_we   = ctrl.reg_we & rst_n;
        wb_val  = ctrl.wb_from_mem ? mem_rdata : alu_y;
        dst_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
    end

    // Next-address selection: sequential or branch target.
    always_comb begin
        pc_plus4    = pc_q + XLEN'(4);
        br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        take_branch = ctrl.is_branch & alu_zero;
        pc_next     = take_branch ? br_target : pc_plus4;
    end

    // Drive the commit trace ports.
    always_comb begin
        pc_o      = pc_q;
        instr_o   = instr;
        wb_en_o   = rf_we && (dst_idx != '0);
        wb_reg_o  = dst_idx;
        wb_data_o = wb_val;
        st_en_o   = dm_we;
        st_addr_o = alu_y;
        st_data_o = rt_val;
    end

endmodule

// File: rtl/sc_cpu_chk.sv
// Protocol checker for the single-cycle core, bound to every sc_cpu instance.
// Assumes only the top-level ports are visible.
module sc_cpu_chk
    import cpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        wb_en_o,
    input logic [4:0]  wb_reg_o,
    input logic        st_en_o
);

    logic [5:0]  op;
    logic [31:0] bofs;
    logic        known;

    // Field views of the executing instruction.
    always_comb begin
        op    = instr_o[31:26];
        bofs  = {{14{instr_o[15]}}, instr_o[15:0], 2'b00};
        known = (op == OPC_REG) || (op == OPC_BEQ) || (op == OPC_LOAD) || (op == OPC_STORE);
    end

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00); // R7

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OPC_BEQ) |=> (pc_o == $past(pc_o) + 32'd4)); // R1

    AST_BRANCH_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_BEQ) |=> ((pc_o == $past(pc_o) + 32'd4) ||
                             (pc_o == $past(pc_o) + 32'd4 + $past(bofs)))); // R2

    AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_BEQ) |-> (!wb_en_o && !st_en_o)); // R2

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        st_en_o |-> !wb_en_o); // R5

    AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_reg_o != 5'd0)); // R6

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (!wb_en_o && !st_en_o)); // R8

endmodule

bind sc_cpu sc_cpu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_o     (pc_o),
    .instr_o  (instr_o),
    .wb_en_o  (wb_en_o),
    .wb_reg_o (wb_reg_o),
    .st_en_o  (st_en_o)
);

// File: tb/sim_sc_cpu.sv
`timescale 1ns/1ps
module sim_sc_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
    logic        wb_en_o, st_en_o;
    logic [4:0]  wb_reg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sc_cpu #(.IMEM_WORDS(32), .DMEM_WORDS(32), .NREGS(32)) u0 (
        .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .instr_o(instr_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] pc;
        logic        wb;
        logic [4:0]  wr;
        logic [31:0] wd;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd4, 32'd0,  1'b1, 5'd1,  32'd7,          1'b0, 32'd0,  32'd0}, // R4 lw r1
        '{4'd4, 32'd4,  1'b1, 5'd2,  32'd5,          1'b0, 32'd0,  32'd0}, // R4 lw r2
        '{4'd4, 32'd8,  1'b1, 5'd3,  32'hFFFF_FFFE,  1'b0, 32'd0,  32'd0}, // R4 lw r3
        '{4'd3, 32'd12, 1'b1, 5'd4,  32'd12,         1'b0, 32'd0,  32'd0}, // R3 add
        '{4'd3, 32'd16, 1'b1, 5'd5,  32'hFFFF_FFFE,  1'b0, 32'd0,  32'd0}, // R3 sub
        '{4'd3, 32'd20, 1'b1, 5'd6,  32'd5,          1'b0, 32'd0,  32'd0}, // R3 and
        '{4'd3, 32'd24, 1'b1, 5'd7,  32'd7,          1'b0, 32'd0,  32'd0}, // R3 or
        '{4'd3, 32'd28, 1'b1, 5'd8,  32'd1,          1'b0, 32'd0,  32'd0}, // R3 slt true
        '{4'd3, 32'd32, 1'b1, 5'd9,  32'd0,          1'b0, 32'd0,  32'd0}, // R3 slt false
        '{4'd6, 32'd36, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}, // R6 write r0
        '{4'd5, 32'd40, 1'b0, 5'd0,  32'd0,          1'b1, 32'd16, 32'd12}, // R5 sw, r0 still 0
        '{4'd5, 32'd44, 1'b0, 5'd0,  32'd0,          1'b1, 32'd8,  32'd7}, // R5 negative offset
        '{4'd7, 32'd48, 1'b1, 5'd10, 32'd12,         1'b0, 32'd0,  32'd0}, // R7 low bits ignored
        '{4'd2, 32'd52, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}, // R2 taken
        '{4'd2, 32'd64, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}, // R2 not taken
        '{4'd8, 32'd68, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}, // R8 illegal opcode
        '{4'd2, 32'd72, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}, // R2 backward
        '{4'd1, 32'd0,  1'b1, 5'd1,  32'd7,          1'b0, 32'd0,  32'd0}  // R1 wrapped to 0
    };

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #1;
        u0.u_imem.g_ro.rom[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        u0.u_imem.g_ro.rom[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        u0.u_imem.g_ro.rom[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
        u0.u_imem.g_ro.rom[3]  = enc_r(6'h20, 5'd1, 5'd2, 5'd4);
        u0.u_imem.g_ro.rom[4]  = enc_r(6'h22, 5'd2, 5'd1, 5'd5);
        u0.u_imem.g_ro.rom[5]  = enc_r(6'h24, 5'd1, 5'd2, 5'd6);
        u0.u_imem.g_ro.rom[6]  = enc_r(6'h25, 5'd1, 5'd2, 5'd7);
        u0.u_imem.g_ro.rom[7]  = enc_r(6'h2A, 5'd3, 5'd1, 5'd8);
        u0.u_imem.g_ro.rom[8]  = enc_r(6'h2A, 5'd1, 5'd3, 5'd9);
        u0.u_imem.g_ro.rom[9]  = enc_r(6'h20, 5'd1, 5'd2, 5'd0);
        u0.u_imem.g_ro.rom[10] = enc_i(6'h2B, 5'd0, 5'd4, 16'd16);
        u0.u_imem.g_ro.rom[11] = enc_i(6'h2B, 5'd4, 5'd1, 16'hFFFC);
        u0.u_imem.g_ro.rom[12] = enc_i(6'h23, 5'd4, 5'd10, 16'd6);
        u0.u_imem.g_ro.rom[13] = enc_i(6'h04, 5'd3, 5'd5, 16'd2);
        u0.u_imem.g_ro.rom[14] = enc_r(6'h20, 5'd1, 5'd1, 5'd11);
        u0.u_imem.g_ro.rom[15] = enc_r(6'h20, 5'd2, 5'd2, 5'd11);
        u0.u_imem.g_ro.rom[16] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
        u0.u_imem.g_ro.rom[17] = 32'hFC00_0000;
        u0.u_imem.g_ro.rom[18] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFED);
        for (int k = 0; k < 32; k++) u0.u_dmem.g_rw.mem[k] = 32'd0;
        u0.u_dmem.g_rw.mem[0] = 32'd7;
        u0.u_dmem.g_rw.mem[1] = 32'd5;
        u0.u_dmem.g_rw.mem[2] = 32'hFFFF_FFFE;

        // Reset state (R1)
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "reset pc", pc_o, 32'd0);
        chk("R1", "reset wb_en", {31'd0, wb_en_o}, 32'd0);
        chk("R1", "reset st_en", {31'd0, st_en_o}, 32'd0);
        rst_n = 1'b1;

        // Table walk (R9: trace shows each commit in its own cycle)
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            #1;
            chk(rq, $sformatf("row %0d pc", i), pc_o, VEC[i].pc);
            chk(rq, $sformatf("row %0d wb_en", i), {31'd0, wb_en_o}, {31'd0, VEC[i].wb});
            if (VEC[i].wb) begin
                chk(rq, $sformatf("row %0d wb_reg", i), {27'd0, wb_reg_o}, {27'd0, VEC[i].wr});
                chk(rq, $sformatf("row %0d wb_data", i), wb_data_o, VEC[i].wd);
            end
            chk(rq, $sformatf("row %0d st_en", i), {31'd0, st_en_o}, {31'd0, VEC[i].st});
            if (VEC[i].st) begin
                chk(rq, $sformatf("row %0d st_addr", i), st_addr_o, VEC[i].sa);
                chk(rq, $sformatf("row %0d st_data", i), st_data_o, VEC[i].sd);
            end
            @(negedge clk);
        end

        // Directed: reset mid-run suppresses the pending load write (R1)
        #1;
        chk("R1", "pc before reset", pc_o, 32'd4);
        rst_n = 1'b0;
        #1;
        chk("R1", "write gated in reset", {31'd0, wb_en_o}, 32'd0);
        @(negedge clk); #1;
        chk("R1", "pc after mid reset", pc_o, 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "restart wb_en", {31'd0, wb_en_o}, 32'd1);
        chk("R4", "restart load value", wb_data_o, 32'd7);
        @(negedge clk); #1;
        chk("R1", "restart advance", pc_o, 32'd4);
        chk("R4", "second load after restart", wb_data_o, 32'd5);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule